// File: doc/BRIEF.md
# SPI Master with Per-Frame Command FIFO

This block is an SPI bus master that takes its work as 32-bit command words. Each word carries one frame of data together with how that frame is to be sent: which peripheral select to drive, which of eight attribute sets to use (frame length, clock polarity, clock phase, bit order), and whether the select should stay asserted once the frame ends. The words queue in a four-entry transmit FIFO. The shift engine pops one, applies its attribute set, drives the selects and clock, and shifts the frame out while it samples the returning line. Every received frame goes into a four-entry receive FIFO.

Frame pacing comes from an external half-period tick supplied by a separate rate divider. Control inputs enable master operation, halt new frames, and flush either FIFO. A status word reports both FIFO levels, a running flag and two sticky error flags. A driver that needs a multi-frame transaction sets the keep-select flag on every word except the last.

Top module: `spi_cmd_master`

## Requirements
- R1: A command word is decoded as: bit 31 keep-select, bits 30:28 attribute-set index, bits 21:16 one-hot select vector, bits 15:0 data. Bits 27:22 are ignored. A frame is len_m1+1 bits long, where len_m1 is the 4-bit length field of the chosen set.
- R2: Each attribute set is 7 bits {lsb_first[6], cpha[5], cpol[4], len_m1[3:0]}, and set n sits at cfg_attr_table[7n+6:7n]. sclk idles at cpol. With cpha=0, data is sampled on the leading sclk edge and changes on the trailing edge. With cpha=1, data changes on the leading edge and is sampled on the trailing edge.
- R3: With lsb_first=1, bit 0 of the data goes out first. Otherwise bit len_m1 goes out first. Received bits are placed by the same rule.
- R4: sel_out[i] sits at cfg_sel_idle_high[i] when select i is not driven. It takes the opposite level while a frame whose select vector has bit i set holds the select.
- R5: If keep-select is 1, the select stays driven after the frame ends, until the next frame loads its own vector. If keep-select is 0, every select returns to its idle level at the end of the frame.
- R6: Each finished frame enters the receive FIFO in order. A pop places the oldest entry on rx_word one cycle later, with the received bits in 15:0 and every bit above the frame length zero.
- R7: Each FIFO holds 4 entries. status_word[15:12] is the transmit level and status_word[7:4] is the receive level.
- R8: While cfg_halt is 1, no new frame starts. A frame already started runs to completion.
- R9: A one-cycle pulse on flush_tx or flush_rx empties the matching FIFO on the next clock. Flushed commands are never shifted.
- R10: A push to a full transmit FIFO is discarded and sets status_word[25], which stays set until reset.
- R11: A pop from an empty receive FIFO leaves rx_word unchanged and sets status_word[17], which stays set until reset.
- R12: No frame starts unless cfg_master is 1. status_word[30] reads 1 exactly when cfg_master is 1 and cfg_halt is 0.
- R13: A frame does not start while the receive FIFO is full. It starts once a pop frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | Master operation enable |
| cfg_halt | input | 1 | Blocks the start of new frames |
| cfg_sel_idle_high | input | 6 | Idle level of each select line |
| cfg_attr_table | input | 56 | Eight 7-bit attribute sets |
| flush_tx | input | 1 | Empty the transmit FIFO (pulse) |
| flush_rx | input | 1 | Empty the receive FIFO (pulse) |
| bit_tick | input | 1 | Half-period pacing strobe from the rate divider |
| tx_push | input | 1 | Write tx_word into the transmit FIFO |
| tx_word | input | 32 | Command word |
| rx_pop | input | 1 | Take the oldest received frame |
| rx_word | output | 16 | Last popped received frame |
| status_word | output | 32 | Levels, running flag and sticky error flags |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_out | output | 6 | Peripheral select lines |

## Verification
The bench exercises all four clock-polarity and phase combinations with 8-, 12- and 16-bit frames, in both bit orders. A design with a phase or order fault puts bits on the wire at the wrong edge or in reversed order, and a loopback that inverts the data also scrambles the received words. It targets a select that idles low, where a design with a fixed active-low select drives the wrong level. It checks keep-select chains, where a design that always releases the select drops it between frames. It also halts the block while a frame is in flight, where a design that aborts on halt loses the receive entry. Boundary cases cover a push into a full queue, a pop from an empty queue, flushes of queued commands, master disable, and a full receive queue. A faulty design would shift dropped or flushed commands, or overwrite unread receive data.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int DATA_W    = 16;
    localparam int SEL_W     = 6;
    localparam int IDX_W     = 3;
    localparam int ATTR_W    = 7;
    localparam int WORD_W    = 32;

    // status word field positions
    localparam int STAT_RUN  = 30;
    localparam int STAT_OVF  = 25;
    localparam int STAT_UNF  = 17;
    localparam int STAT_TXL  = 12;
    localparam int STAT_RXL  = 4;

    typedef struct packed {
        logic              keep_sel;
        logic [IDX_W-1:0]  attr_idx;
        logic [5:0]        spare;
        logic [SEL_W-1:0]  sel_vec;
        logic [DATA_W-1:0] data;
    } tx_cmd_t;

    typedef struct packed {
        logic       lsb_first;
        logic       cpha;
        logic       cpol;
        logic [3:0] len_m1;
    } frame_attr_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LEAD  = 2'd1,
        ENG_SHIFT = 2'd2,
        ENG_TRAIL = 2'd3
    } eng_state_t;

    // wire position of the k-th bit of a frame
    function automatic logic [3:0] bit_slot(input logic [3:0] k,
                                            input logic [3:0] len_m1,
                                            input logic       lsb_first);
        return lsb_first ? k : (len_m1 - k);
    endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign dout    = store[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_cmd_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int TABLE_W = NUM_SETS * ATTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              start_ok,
    input  tx_cmd_t           cmd,
    input  logic [TABLE_W-1:0] attr_table,
    input  logic              miso,
    output logic              cmd_pop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    output logic              sel_active,
    output logic [SEL_W-1:0]  sel_vec
);

    eng_state_t        state;
    frame_attr_t       attr_q;
    frame_attr_t       attr_n;
    logic [DATA_W-1:0] data_q;
    logic              keep_q;
    logic [4:0]        edge_q;
    logic [3:0]        edge_k;
    logic              last_edge;
    logic              sample_now;

    assign attr_n     = frame_attr_t'(attr_table[int'(cmd.attr_idx) * ATTR_W +: ATTR_W]);
    assign cmd_pop    = (state == ENG_IDLE) && start_ok;
    assign edge_k     = edge_q[4:1];
    assign last_edge  = (edge_q == {attr_q.len_m1, 1'b1});
    // even edges lead, odd edges trail; phase picks which one samples
    assign sample_now = edge_q[0] ^ ~attr_q.cpha;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            attr_q     <= '0;
            data_q     <= '0;
            keep_q     <= 1'b0;
            edge_q     <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            sclk       <= 1'b0;
            mosi       <= 1'b0;
            sel_active <= 1'b0;
            sel_vec    <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (start_ok) begin
                        attr_q     <= attr_n;
                        data_q     <= cmd.data;
                        keep_q     <= cmd.keep_sel;
                        sel_vec    <= cmd.sel_vec;
                        sel_active <= 1'b1;
                        sclk       <= attr_n.cpol;
                        edge_q     <= '0;
                        rx_data    <= '0;
                        if (!attr_n.cpha) begin
                            mosi <= cmd.data[bit_slot(4'd0, attr_n.len_m1, attr_n.lsb_first)];
                        end
                        state <= ENG_LEAD;
                    end
                end
                ENG_LEAD: begin
                    if (bit_tick) state <= ENG_SHIFT;
                end
                ENG_SHIFT: begin
                    if (bit_tick) begin
                        sclk <= ~sclk;
                        if (sample_now) begin
                            rx_data[bit_slot(edge_k, attr_q.len_m1, attr_q.lsb_first)] <= miso;
                        end else if (!last_edge) begin
                            mosi <= data_q[bit_slot(attr_q.cpha ? edge_k : edge_k + 4'd1,
                                                    attr_q.len_m1, attr_q.lsb_first)];
                        end
                        if (last_edge) begin
                            rx_valid <= 1'b1;
                            state    <= ENG_TRAIL;
                        end else begin
                            edge_q <= edge_q + 5'd1;
                        end
                    end
                end
                ENG_TRAIL: begin
                    if (bit_tick) begin
                        sel_active <= keep_q;
                        state      <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_sel_drive.sv
module spi_sel_drive #(
    parameter int NUM_SEL = 6
) (
    input  logic               active,
    input  logic [NUM_SEL-1:0] vec,
    input  logic [NUM_SEL-1:0] idle_high,
    output logic [NUM_SEL-1:0] sel_out
);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel_out[i] = (active && vec[i]) ? ~idle_high[i] : idle_high[i];
    end

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int NUM_SETS = 8,
    localparam int TXC_W   = $clog2(TX_DEPTH + 1),
    localparam int RXC_W   = $clog2(RX_DEPTH + 1),
    localparam int TABLE_W = NUM_SETS * ATTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_master,
    input  logic               cfg_halt,
    input  logic [SEL_W-1:0]   cfg_sel_idle_high,
    input  logic [TABLE_W-1:0] cfg_attr_table,
    input  logic               flush_tx,
    input  logic               flush_rx,
    input  logic               bit_tick,
    input  logic               tx_push,
    input  logic [WORD_W-1:0]  tx_word,
    input  logic               rx_pop,
    output logic [DATA_W-1:0]  rx_word,
    output logic [WORD_W-1:0]  status_word,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [SEL_W-1:0]   sel_out
);

    logic [WORD_W-1:0] tx_head;
    logic [TXC_W-1:0]  tx_count;
    logic              tx_full, tx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [RXC_W-1:0]  rx_count;
    logic              rx_full, rx_empty;
    logic              eng_pop, eng_rx_valid, eng_sel_active, start_ok;
    logic [DATA_W-1:0] eng_rx_data;
    logic [SEL_W-1:0]  eng_sel_vec;
    logic              running, ovf_q, unf_q;

    assign running  = cfg_master & ~cfg_halt;
    assign start_ok = running & ~tx_empty & ~rx_full & ~flush_tx;

    spi_cmd_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_tx),
        .push  (tx_push),
        .din   (tx_word),
        .pop   (eng_pop),
        .dout  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_cmd_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_rx),
        .push  (eng_rx_valid),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_frame_engine #(.NUM_SETS(NUM_SETS)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .start_ok   (start_ok),
        .cmd        (tx_cmd_t'(tx_head)),
        .attr_table (cfg_attr_table),
        .miso       (miso),
        .cmd_pop    (eng_pop),
        .rx_valid   (eng_rx_valid),
        .rx_data    (eng_rx_data),
        .sclk       (sclk),
        .mosi       (mosi),
        .sel_active (eng_sel_active),
        .sel_vec    (eng_sel_vec)
    );

    spi_sel_drive #(.NUM_SEL(SEL_W)) u_sel (
        .active    (eng_sel_active),
        .vec       (eng_sel_vec),
        .idle_high (cfg_sel_idle_high),
        .sel_out   (sel_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            if (rx_pop && !rx_empty && !flush_rx) rx_word <= rx_head;
            if (tx_push && tx_full && !flush_tx)  ovf_q   <= 1'b1;
            if (rx_pop && rx_empty)               unf_q   <= 1'b1;
        end
    end

    always_comb begin
        status_word                        = '0;
        status_word[STAT_RUN]              = running;
        status_word[STAT_OVF]              = ovf_q;
        status_word[STAT_UNF]              = unf_q;
        status_word[STAT_TXL +: 4]         = 4'(tx_count);
        status_word[STAT_RXL +: 4]         = 4'(rx_count);
    end

endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk
    import spi_cmd_pkg::*;
#(
    parameter int TX_DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_halt,
    input logic              flush_tx,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic [WORD_W-1:0] status_word,
    input logic [DATA_W-1:0] rx_word,
    input logic [SEL_W-1:0]  sel_out,
    input logic [SEL_W-1:0]  cfg_sel_idle_high,
    input logic              eng_pop,
    input logic              eng_sel_active
);

    assert_tx_bound_R7: assert property (@(posedge clk) disable iff (rst)
        status_word[STAT_TXL +: 4] <= 4'(TX_DEPTH));

    assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_halt |-> !eng_pop);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush_tx |=> (status_word[STAT_TXL +: 4] == 4'd0));

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        status_word[STAT_OVF] |=> status_word[STAT_OVF]);

    assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        status_word[STAT_UNF] |=> status_word[STAT_UNF]);

    assert_empty_pop_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |=> $stable(rx_word));

    assert_idle_selects_R4: assert property (@(posedge clk) disable iff (rst)
        !eng_sel_active |-> (sel_out == cfg_sel_idle_high));

endmodule

bind spi_cmd_master spi_cmd_master_chk #(.TX_DEPTH(TX_DEPTH)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .cfg_halt          (cfg_halt),
    .flush_tx          (flush_tx),
    .rx_pop            (rx_pop),
    .rx_empty          (rx_empty),
    .status_word       (status_word),
    .rx_word           (rx_word),
    .sel_out           (sel_out),
    .cfg_sel_idle_high (cfg_sel_idle_high),
    .eng_pop           (eng_pop),
    .eng_sel_active    (eng_sel_active)
);

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1;
    logic        cfg_halt = 1'b0;
    logic [5:0]  cfg_sel_idle_high = 6'b111101;
    logic [55:0] cfg_attr_table = '0;
    logic        flush_tx = 1'b0;
    logic        flush_rx = 1'b0;
    logic        bit_tick = 1'b1;
    logic        tx_push = 1'b0;
    logic [31:0] tx_word = '0;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_word;
    logic [31:0] status_word;
    logic        sclk, mosi, miso;
    logic [5:0]  sel_out;

    assign miso = ~mosi;   // inverting loopback

    always #10 clk = ~clk; // 50 MHz

    spi_cmd_master uut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_halt(cfg_halt),
        .cfg_sel_idle_high(cfg_sel_idle_high), .cfg_attr_table(cfg_attr_table),
        .flush_tx(flush_tx), .flush_rx(flush_rx), .bit_tick(bit_tick),
        .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop), .rx_word(rx_word),
        .status_word(status_word), .sclk(sclk), .mosi(mosi), .miso(miso),
        .sel_out(sel_out)
    );

    // attribute sets {lsb_first, cpha, cpol, len_m1}
    logic [6:0] attr_set [8];
    initial begin
        attr_set[0] = 7'b0000111;  // 8-bit, mode 0, msb first
        attr_set[1] = 7'b0111111;  // 16-bit, cpol 1, cpha 1, msb first
        attr_set[2] = 7'b1100111;  // 8-bit, cpol 0, cpha 1, lsb first
        attr_set[3] = 7'b1011011;  // 12-bit, cpol 1, cpha 0, lsb first
        for (int i = 4; i < 8; i++) attr_set[i] = 7'b0000111;
        for (int i = 0; i < 8; i++) cfg_attr_table[i*7 +: 7] = attr_set[i];
    end

    typedef struct {
        logic [15:0] data;
        logic [6:0]  attr;
        logic [5:0]  sel_exp;
    } frame_t;

    frame_t      wire_q [$];
    logic [15:0] rx_q [$];
    int          n_total = 0, n_fail = 0, strays = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] active_pattern(input int sel_idx);
        logic [5:0] p = cfg_sel_idle_high;
        p[sel_idx] = ~cfg_sel_idle_high[sel_idx];
        return p;
    endfunction

    task automatic push_raw(input logic [15:0] data, input int set, input int sel_idx, input bit keep);
        @(negedge clk);
        tx_word = {keep, 3'(set), 6'b101010, 6'(1 << sel_idx), data};
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    // driver: queues the expected wire frame, then pushes the command
    task automatic send(input logic [15:0] data, input int set, input int sel_idx, input bit keep);
        frame_t f;
        f.data = data;
        f.attr = attr_set[set];
        f.sel_exp = active_pattern(sel_idx);
        wire_q.push_back(f);
        push_raw(data, set, sel_idx, keep);
    endtask

    task automatic pop_check(input string req);
        logic [15:0] exp;
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        exp = (rx_q.size() > 0) ? rx_q.pop_front() : 16'hxxxx;
        check(rx_word === exp, req, {16'h0, rx_word}, {16'h0, exp});
    endtask

    task automatic pulse_flush(input bit tx_side);
        @(negedge clk);
        if (tx_side) flush_tx = 1'b1; else flush_rx = 1'b1;
        @(negedge clk);
        flush_tx = 1'b0;
        flush_rx = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int tx_lvl(); return int'(status_word[15:12]); endfunction
    function automatic int rx_lvl(); return int'(status_word[7:4]); endfunction

    // monitor: reconstructs frames on the wire and compares with the queue
    frame_t      cur;
    logic        prev_sck, seen_lead, tail_due, lead;
    logic [15:0] got;
    int          nbits;

    always @(negedge clk) begin
        if (rst) begin
            prev_sck = sclk; seen_lead = 0; tail_due = 0; nbits = 0; got = '0;
        end else begin
            if (sclk !== prev_sck) begin
                if (tail_due) begin
                    tail_due = 0;
                end else if (wire_q.size() == 0) begin
                    strays++;
                end else begin
                    cur  = wire_q[0];
                    lead = (sclk != cur.attr[4]);
                    if (lead || seen_lead) begin
                        if (lead) seen_lead = 1;
                        if (lead ^ cur.attr[5]) begin
                            if (nbits == 0)
                                check(sel_out == cur.sel_exp, "R4 select level during frame",
                                      {26'h0, sel_out}, {26'h0, cur.sel_exp});
                            if (cur.attr[6]) got[nbits] = mosi;
                            else             got[int'(cur.attr[3:0]) - nbits] = mosi;
                            nbits++;
                            if (nbits == int'(cur.attr[3:0]) + 1) begin : fin
                                logic [15:0] mask;
                                mask = 16'((32'h1 << nbits) - 1);
                                check(got == (cur.data & mask), "R1 R2 R3 wire bits",
                                      {16'h0, got}, {16'h0, cur.data & mask});
                                rx_q.push_back(~cur.data & mask);
                                void'(wire_q.pop_front());
                                tail_due  = !cur.attr[5];
                                nbits     = 0;
                                seen_lead = 0;
                                got       = '0;
                            end
                        end
                    end
                end
            end
            prev_sck = sclk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_rx;
        idle(5);
        rst = 1'b0;
        idle(2);
        // reset state
        check(tx_lvl() == 0 && rx_lvl() == 0, "R7 levels after reset", status_word, 32'h0);
        check(status_word[30] == 1'b1, "R12 running flag", status_word, 32'h4000_0000);
        check(status_word[25] == 0 && status_word[17] == 0, "R10 R11 flags clear", status_word, 32'h0);
        check(sel_out == cfg_sel_idle_high, "R4 idle selects", {26'h0, sel_out}, {26'h0, cfg_sel_idle_high});

        // mixed modes, orders, lengths, selects (select 1 idles low)
        send(16'h00A5, 0, 0, 0);
        send(16'h1234, 1, 1, 0);
        send(16'h00C3, 2, 3, 0);
        send(16'h0ABC, 3, 5, 0);
        idle(200);
        check(wire_q.size() == 0, "R1 all frames shifted", wire_q.size(), 0);
        check(rx_lvl() == 4, "R6 R7 receive level", rx_lvl(), 4);
        check(sclk == 1'b1, "R2 clock idles at cpol", sclk, 1);
        check(sel_out == cfg_sel_idle_high, "R5 release after frame", {26'h0, sel_out}, {26'h0, cfg_sel_idle_high});
        repeat (4) pop_check("R6 received frame");

        // keep-select chain
        send(16'h0055, 0, 2, 1);
        idle(60);
        check(sel_out == active_pattern(2), "R5 select held", {26'h0, sel_out}, {26'h0, active_pattern(2)});
        send(16'h00AA, 0, 2, 0);
        idle(60);
        check(sel_out == cfg_sel_idle_high, "R5 select released", {26'h0, sel_out}, {26'h0, cfg_sel_idle_high});
        repeat (2) pop_check("R6 chained frame");

        // halt before start
        cfg_halt = 1'b1;
        idle(1);
        check(status_word[30] == 1'b0, "R12 running flag under halt", status_word, 32'h0);
        send(16'h0011, 0, 4, 0);
        send(16'h0022, 2, 4, 0);
        idle(80);
        check(tx_lvl() == 2 && rx_lvl() == 0, "R8 halt holds commands", status_word, 32'h0000_2000);
        cfg_halt = 1'b0;
        idle(150);
        check(tx_lvl() == 0 && rx_lvl() == 2, "R8 resume after halt", status_word, 32'h4000_0020);
        repeat (2) pop_check("R6 after halt");

        // halt during a frame
        send(16'hBEEF, 1, 0, 0);
        send(16'h0077, 0, 0, 0);
        idle(6);
        cfg_halt = 1'b1;
        idle(100);
        check(rx_lvl() == 1 && tx_lvl() == 1, "R8 in-flight frame completes", status_word, 32'h0000_1010);
        cfg_halt = 1'b0;
        idle(80);
        repeat (2) pop_check("R8 frames around halt");

        // overflow
        cfg_halt = 1'b1;
        send(16'h0001, 0, 0, 0);
        send(16'h0002, 0, 0, 0);
        send(16'h0003, 0, 0, 0);
        send(16'h0004, 0, 0, 0);
        push_raw(16'h00FF, 0, 0, 0);
        idle(2);
        check(tx_lvl() == 4, "R7 transmit depth", tx_lvl(), 4);
        check(status_word[25] == 1'b1, "R10 overflow flag", status_word, 32'h0200_0000);
        cfg_halt = 1'b0;
        idle(200);
        check(rx_lvl() == 4 && strays == 0, "R10 dropped push not shifted", strays, 0);

        // receive queue full stalls the next frame
        send(16'h0099, 2, 1, 0);
        idle(100);
        check(tx_lvl() == 1 && rx_lvl() == 4, "R13 stall on full receive queue", status_word, 32'h0000_1040);
        pop_check("R13 first stalled pop");
        idle(80);
        check(tx_lvl() == 0 && rx_lvl() == 4, "R13 frame starts after pop", status_word, 32'h0000_0040);
        repeat (4) pop_check("R6 drain");

        // underflow
        last_rx = rx_word;
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
        check(rx_word == last_rx, "R11 empty pop keeps data", {16'h0, rx_word}, {16'h0, last_rx});
        check(status_word[17] == 1'b1, "R11 underflow flag", status_word, 32'h0002_0000);
        check(status_word[25] == 1'b1, "R10 overflow flag sticky", status_word, 32'h0200_0000);

        // flushes
        cfg_halt = 1'b1;
        push_raw(16'h0101, 0, 0, 0);
        push_raw(16'h0202, 0, 0, 0);
        push_raw(16'h0303, 0, 0, 0);
        check(tx_lvl() == 3, "R9 queued before flush", tx_lvl(), 3);
        pulse_flush(1);
        check(tx_lvl() == 0, "R9 transmit flush", tx_lvl(), 0);
        cfg_halt = 1'b0;
        idle(100);
        check(rx_lvl() == 0 && strays == 0, "R9 flushed commands not shifted", strays, 0);
        send(16'h0044, 0, 0, 0);
        send(16'h0088, 0, 0, 0);
        idle(80);
        check(rx_lvl() == 2, "R9 receive before flush", rx_lvl(), 2);
        pulse_flush(0);
        check(rx_lvl() == 0, "R9 receive flush", rx_lvl(), 0);
        rx_q.delete();

        // master disabled
        cfg_master = 1'b0;
        idle(1);
        check(status_word[30] == 1'b0, "R12 running flag off", status_word, 32'h0);
        push_raw(16'h0066, 0, 0, 0);
        idle(100);
        check(tx_lvl() == 1 && strays == 0, "R12 no frame without master", status_word, 32'h0000_1000);
        pulse_flush(1);
        cfg_master = 1'b1;
        idle(20);
        check(wire_q.size() == 0 && strays == 0, "R1 no leftover frames", strays, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule